// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block runs the payment side of a single-item vending machine. It takes coins one at a time, keeps the credit paid so far, and sells the item as soon as the credit covers the price of 20 cents. In the cycle that the paying coin arrives, it raises a vend pulse and reports any overpayment as change. It then drops back to zero credit, ready for the next customer.

Each coin arrives as a one-cycle strobe with a 2-bit type code. Coin validation, mechanical timing, cancel or refund, and multiple products are left to other logic. All amounts inside the block are counted in 5-cent units. The credit can only be 0, 5, 10 or 15 cents. A credit of 20 cents or more never lasts past the cycle that produced it.

Top module: `vend_top`

## Requirements
- R1: After a synchronous reset the credit is zero, so two nickels and a nickel (15 cents) after reset produce no vend. With no coin applied, vendPulse and changeUnits are 0.
- R2: A coin is taken only when coinStrobe is 1. Its code sets its value: 2'b01 is a nickel (1 unit), 2'b10 is a dime (2 units), 2'b11 is a quarter (5 units). One unit is 5 cents.
- R3: A cycle with coinStrobe low, or with coinStrobe high and code 2'b00, leaves the credit unchanged and gives no vend.
- R4: vendPulse is 1 in the same cycle as a taken coin whose value plus the stored credit is 4 units or more. Otherwise it is 0.
- R5: changeUnits equals (credit + coin value − 4) in that vend cycle, so its values run from 0 to 4 units (0 to 20 cents). In every cycle without a vend it is 0.
- R6: After a vend, the credit is zero at the next clock edge.
- R7: A taken coin that leaves the total below 4 units adds its value to the credit.
- R8: A vend lasts exactly one cycle per paying coin. An idle cycle after a vend shows vendPulse at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coinStrobe | input | 1 | One-cycle coin arrival strobe |
| coinCode | input | 2 | Coin type: 00 none, 01 nickel, 10 dime, 11 quarter |
| vendPulse | output | 1 | Dispense the item in this cycle |
| changeUnits | output | 3 | Change owed, in 5-cent units, valid with vendPulse |

## Verification
Both outputs are Mealy outputs: they respond in the same cycle as the coin, with no register in between. The bench therefore drives each coin just after a falling edge and reads vendPulse and changeUnits one time unit later, before the rising edge that stores the new credit. The effect on the credit becomes visible only in the next coin's outcome, one clock later. So the resets, ignored cycles and cleared credit after a vend are each checked by the vend decision of the coin that follows.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // All amounts are in 5-cent units.
  localparam int NICKEL_UNITS  = 1;
  localparam int DIME_UNITS    = 2;
  localparam int QUARTER_UNITS = 5;
  localparam int PRICE_UNITS   = 4;

  localparam int CREDIT_W = $clog2(PRICE_UNITS);
  localparam int SUM_W    = $clog2(PRICE_UNITS + QUARTER_UNITS);
  localparam int CHANGE_W = $clog2(QUARTER_UNITS);
  localparam int CODE_W   = 2;

  typedef enum logic [CODE_W-1:0] {
    COIN_NONE    = 2'b00,
    COIN_NICKEL  = 2'b01,
    COIN_DIME    = 2'b10,
    COIN_QUARTER = 2'b11
  } coin_e;

  // Strobes from control to the arithmetic path.
  typedef struct packed {
    logic                take;
    logic [SUM_W-1:0]    addUnits;
    logic [CREDIT_W-1:0] creditUnits;
  } ctrlStrb_t;
endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
(
  input  ctrlStrb_t           strb,
  output logic                atPrice,
  output logic [SUM_W-1:0]    sumUnits,
  output logic [CHANGE_W-1:0] changeUnits
);
  always_comb begin
    sumUnits = SUM_W'(strb.creditUnits) + strb.addUnits;
    atPrice  = strb.take && (sumUnits >= SUM_W'(PRICE_UNITS));
    if (atPrice) changeUnits = CHANGE_W'(sumUnits - SUM_W'(PRICE_UNITS));
    else         changeUnits = '0;
  end
endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              coinStrobe,
  input  logic [CODE_W-1:0] coinCode,
  input  logic              atPrice,
  input  logic [SUM_W-1:0]  sumUnits,
  output ctrlStrb_t         strb,
  output logic              vendPulse
);
  logic [CREDIT_W-1:0] creditQ;
  logic [CREDIT_W-1:0] creditD;
  logic [SUM_W-1:0]    coinUnits;

  always_comb begin
    case (coin_e'(coinCode))
      COIN_NICKEL:  coinUnits = SUM_W'(NICKEL_UNITS);
      COIN_DIME:    coinUnits = SUM_W'(DIME_UNITS);
      COIN_QUARTER: coinUnits = SUM_W'(QUARTER_UNITS);
      default:      coinUnits = '0;
    endcase
    strb.take        = coinStrobe && (coin_e'(coinCode) != COIN_NONE);
    strb.addUnits    = coinUnits;
    strb.creditUnits = creditQ;
    vendPulse        = atPrice;
    if (!strb.take)   creditD = creditQ;
    else if (atPrice) creditD = '0;
    else              creditD = CREDIT_W'(sumUnits);
  end

  always_ff @(posedge clk) begin
    if (rst) creditQ <= '0;
    else     creditQ <= creditD;
  end
endmodule

// File: rtl/vend_top.sv
module vend_top
  import vend_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                coinStrobe,
  input  logic [1:0]          coinCode,
  output logic                vendPulse,
  output logic [2:0]          changeUnits
);
  ctrlStrb_t        strb;
  logic             atPrice;
  logic [SUM_W-1:0] sumUnits;

  vend_control u_control (
    .clk(clk), .rst(rst), .coinStrobe(coinStrobe), .coinCode(coinCode),
    .atPrice(atPrice), .sumUnits(sumUnits), .strb(strb), .vendPulse(vendPulse)
  );

  vend_datapath u_datapath (
    .strb(strb), .atPrice(atPrice), .sumUnits(sumUnits),
    .changeUnits(changeUnits)
  );
endmodule

// File: rtl/vend_checker.sv
module vend_checker (
  input logic       clk,
  input logic       rst,
  input logic       coinStrobe,
  input logic [1:0] coinCode,
  input logic       vendPulse,
  input logic [2:0] changeUnits
);
  a_r5_change_only_on_vend: assert property (@(posedge clk) disable iff (rst)
    !vendPulse |-> changeUnits == 3'd0);

  a_r5_change_bound: assert property (@(posedge clk) disable iff (rst)
    changeUnits <= 3'd4);

  a_r3_idle_no_vend: assert property (@(posedge clk) disable iff (rst)
    (!coinStrobe || coinCode == 2'b00) |-> !vendPulse);

  a_r4_quarter_pays: assert property (@(posedge clk) disable iff (rst)
    (coinStrobe && coinCode == 2'b11) |-> (vendPulse && changeUnits != 3'd0));

  a_r6_nickel_after_vend: assert property (@(posedge clk) disable iff (rst)
    (vendPulse && !$past(rst)) ##1 (coinStrobe && coinCode == 2'b01) |-> !vendPulse);
endmodule

bind vend_top vend_checker u_checker (
  .clk(clk), .rst(rst), .coinStrobe(coinStrobe), .coinCode(coinCode),
  .vendPulse(vendPulse), .changeUnits(changeUnits)
);

// File: tb/tb_vend_top.sv
module tb_vend_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;
  // {strobe, code[1:0], expVend, expChange[2:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_01_0_000, // N   0->1
    7'b0_11_0_000, // no strobe, ignored (R3)
    7'b1_00_0_000, // code none, ignored (R3)
    7'b1_10_0_000, // D   1->3 (R7)
    7'b1_01_1_000, // N   3->4 exact vend (R4)
    7'b1_10_0_000, // D   0->2 (R6)
    7'b1_10_1_000, // D   2->4 vend
    7'b1_11_1_001, // Q   0->5 change 1
    7'b1_01_0_000, // N   0->1
    7'b1_11_1_010, // Q   1->6 change 2
    7'b1_10_0_000, // D   0->2
    7'b1_11_1_011, // Q   2->7 change 3
    7'b1_10_0_000, // D   0->2
    7'b1_01_0_000, // N   2->3
    7'b1_11_1_100, // Q   3->8 change 4 (R5)
    7'b1_10_0_000, // D   0->2
    7'b1_10_1_000, // D   2->4
    7'b1_01_0_000, // N   0->1
    7'b1_01_0_000, // N   1->2
    7'b1_01_0_000, // N   2->3
    7'b1_10_1_001  // D   3->5 change 1
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coinStrobe = 1'b0;
  logic [1:0] coinCode = 2'b00;
  logic       vendPulse;
  logic [2:0] changeUnits;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  vend_top dut (
    .clk(clk), .rst(rst), .coinStrobe(coinStrobe), .coinCode(coinCode),
    .vendPulse(vendPulse), .changeUnits(changeUnits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic expV, input logic [2:0] expC);
    nChecks++;
    if (vendPulse !== expV || changeUnits !== expC) begin
      nFails++;
      $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
               req, vendPulse, changeUnits, expV, expC);
    end
  endtask

  // Drive after the falling edge, sample 1 time unit later, then let the rising edge store.
  task automatic apply(input logic s, input logic [1:0] c, input logic expV,
                       input logic [2:0] expC, input string req);
    @(negedge clk);
    coinStrobe = s;
    coinCode   = c;
    #1;
    check(req, expV, expC);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1 reset idle outputs", 1'b0, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++)
      apply(VEC[i][6], VEC[i][5:4], VEC[i][3], VEC[i][2:0], "R2 R4 R5 R7 vector");
    // R8: idle cycle after a vend
    apply(1'b1, 2'b11, 1'b1, 3'd1, "R4 quarter from zero");
    apply(1'b0, 2'b00, 1'b0, 3'd0, "R8 single-cycle vend");
    // R1: reset clears partial credit
    apply(1'b1, 2'b10, 1'b0, 3'd0, "R7 dime");
    apply(1'b1, 2'b01, 1'b0, 3'd0, "R7 nickel");
    @(negedge clk);
    coinStrobe = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(1'b1, 2'b01, 1'b0, 3'd0, "R1 credit cleared by reset");
    apply(1'b1, 2'b01, 1'b0, 3'd0, "R1 second nickel");
    apply(1'b1, 2'b01, 1'b0, 3'd0, "R1 third nickel");
    apply(1'b1, 2'b01, 1'b1, 3'd0, "R4 fourth nickel pays");
    // R6: a dime right after a vend must not pay
    apply(1'b1, 2'b10, 1'b0, 3'd0, "R6 credit zero after vend");
    // R3: long idle with codes held keeps credit at 2
    apply(1'b0, 2'b10, 1'b0, 3'd0, "R3 idle dime code");
    apply(1'b1, 2'b00, 1'b0, 3'd0, "R3 strobe with none code");
    apply(1'b1, 2'b10, 1'b1, 3'd0, "R3 credit kept, dime pays");
    @(negedge clk);
    coinStrobe = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule